// File: doc/BRIEF.md
# A/D Conversion Sequencer with Priority Injection

This block decides which analog channel a shared A/D converter samples next. It runs four standard modes: fixed channel (once or repeating) and downward scan (once or repeating). It also runs a separate high-priority injected conversion, which has its own result register and its own completion flag. Software sets the mode, the channel and the start bit in a single configuration write. A hardware strobe requests an injection on a chosen channel.

A configuration write never disturbs a conversion that is already running. Its values are held aside and take effect at the next point where the sequencer may change course. In fixed-channel mode that point is the end of every conversion. In scan mode it is the end of channel 0. The converter is a separate unit that takes a start pulse and a channel number, and answers some cycles later with a done pulse and a data word. Only one conversion is ever outstanding.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Mode code 00 (fixed, once) with the start bit set converts the written channel once. The result is stored with its channel number, the standard flag is set and the block returns to idle.
- R2: Mode code 01 (fixed, repeating) converts the held channel again after each conversion while the start bit stays set. A new channel written during a conversion is used from the next conversion on. A write that clears the start bit ends the run after the current conversion.
- R3: Mode code 10 (scan, once) started at channel n converts n, n-1, down to 0, then goes idle. The last stored result is channel 0.
- R4: Mode code 11 (scan, repeating) restarts from the held channel after each channel 0 while the start bit is set. Clearing the start bit stops the run only after the next channel 0.
- R5: If scan mode is written without the start bit while a fixed conversion of channel n>0 runs, channels n-1 down to 0 follow, and the written channel is not used.
- R6: During a scan, writes of channel, mode or start bit take effect only after channel 0 completes.
- R7: While idle, a write with the start bit clear starts no conversion, whatever the mode and channel.
- R8: An injected conversion stores its data in the injected result register and sets the injected flag, not the standard ones. It takes a free converter ahead of a waiting standard conversion, but never interrupts one in flight.
- R9: A start write that arrives at any point during an injected conversion, up to and including its final cycles, neither aborts it nor loses its result. The standard conversion follows the injection.
- R10: The injection-pending output goes high the cycle after a request strobe and falls when that injection completes. Configuration writes, including ones that clear the start bit, do not change it. A request made while one is already pending merges with it.
- R11: Busy rises on the second clock after a start write and falls on the same clock edge that stores the final standard result of a single-mode run.
- R12: The converter start is a one-cycle pulse, issued only when no conversion is outstanding.
- R13: Both completion flags stay set until their clear strobe. A set in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode code: 00 fixed once, 01 fixed repeat, 10 scan once, 11 scan repeat |
| cfg_chan | input | CH_W | Channel number written |
| cfg_start | input | 1 | Start bit written |
| inj_req | input | 1 | Injection request strobe |
| inj_chan | input | CH_W | Channel for the injection request |
| std_irq_clr | input | 1 | Clear strobe for the standard flag |
| inj_irq_clr | input | 1 | Clear strobe for the injected flag |
| cnv_start | output | 1 | Start pulse to the converter |
| cnv_chan | output | CH_W | Channel to the converter, held while converting |
| cnv_done | input | 1 | Conversion-complete pulse from the converter |
| cnv_data | input | DATA_W | Converted value, valid with cnv_done |
| busy | output | 1 | Standard sequence active |
| inj_pending | output | 1 | Injection requested and not yet complete |
| std_result | output | DATA_W | Last standard result |
| std_result_chan | output | CH_W | Channel of the last standard result |
| inj_result | output | DATA_W | Last injected result |
| std_irq | output | 1 | Standard conversion complete flag |
| inj_irq | output | 1 | Injected conversion complete flag |

## Verification
The bench builds the block with eight channels and 10-bit data, so a scan can count down from channel 7. The converter model has a latency of six cycles. That latency leaves a window long enough to sweep a start write across every cycle of an injection, including the cycle in which the result returns. The bench makes each converted value a distinct function of the channel, so the log of issued channels and the stored results both show the order of conversions.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        MODE_FIX_ONCE  = 2'b00,
        MODE_FIX_LOOP  = 2'b01,
        MODE_SCAN_ONCE = 2'b10,
        MODE_SCAN_LOOP = 2'b11
    } scan_mode_e;

    typedef enum logic {
        SRC_STD = 1'b0,
        SRC_INJ = 1'b1
    } conv_src_e;

    localparam int N_FLAGS = 2;
    localparam int FLAG_STD = 0;
    localparam int FLAG_INJ = 1;

    function automatic logic mode_is_scan(scan_mode_e m);
        return m[1];
    endfunction

    function automatic logic mode_is_loop(scan_mode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [1:0]      wr_mode,
    input  logic [CH_W-1:0] wr_chan,
    input  logic            wr_start,
    input  logic            take_i,
    input  logic            stop_i,
    output scan_mode_e      mode_o,
    output logic [CH_W-1:0] chan_o,
    output logic            start_o,
    output logic            restart_o
);

    // Held configuration: consumed by the sequencer only at boundaries.
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_o    <= MODE_FIX_ONCE;
            chan_o    <= '0;
            start_o   <= 1'b0;
            restart_o <= 1'b0;
        end else begin
            if (wr_en) begin
                mode_o    <= scan_mode_e'(wr_mode);
                chan_o    <= wr_chan;
                start_o   <= wr_start;
                restart_o <= wr_start;
            end else begin
                if (take_i) restart_o <= 1'b0;
                if (stop_i) start_o   <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  scan_mode_e      sh_mode,
    input  logic [CH_W-1:0] sh_chan,
    input  logic            sh_start,
    input  logic            sh_restart,
    input  logic            inj_pend,
    input  logic [CH_W-1:0] inj_chan,
    input  logic            cnv_done,
    output logic            cnv_start,
    output logic [CH_W-1:0] cnv_chan,
    output logic            busy,
    output logic            std_done,
    output logic            inj_done,
    output logic [CH_W-1:0] done_chan,
    output logic            take,
    output logic            stop
);

    localparam logic [CH_W-1:0] CH_ONE = CH_W'(1);

    logic            active_q;
    logic            scan_q;
    logic [CH_W-1:0] seq_chan_q;
    logic            fl_q;
    conv_src_e       src_q;
    logic [CH_W-1:0] fl_chan_q;
    logic            start_q;

    logic idle_go, mid_scan, morph, boundary, again;

    always_comb begin
        std_done = cnv_done && fl_q && (src_q == SRC_STD);
        inj_done = cnv_done && fl_q && (src_q == SRC_INJ);
        idle_go  = !active_q && sh_restart;
        mid_scan = scan_q && (fl_chan_q != '0);
        morph    = !scan_q && mode_is_scan(sh_mode) && (fl_chan_q != '0) && !sh_restart;
        boundary = !mid_scan && !morph;
        again    = sh_restart || (sh_start && mode_is_loop(sh_mode));
        take     = idle_go || (std_done && boundary);
        stop     = std_done && boundary && !again;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q   <= 1'b0;
            scan_q     <= 1'b0;
            seq_chan_q <= '0;
            fl_q       <= 1'b0;
            src_q      <= SRC_STD;
            fl_chan_q  <= '0;
            start_q    <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (idle_go) begin
                active_q   <= 1'b1;
                scan_q     <= mode_is_scan(sh_mode);
                seq_chan_q <= sh_chan;
            end
            if (std_done) begin
                if (mid_scan || morph) begin
                    scan_q     <= 1'b1;
                    seq_chan_q <= fl_chan_q - CH_ONE;
                end else if (again) begin
                    scan_q     <= mode_is_scan(sh_mode);
                    seq_chan_q <= sh_chan;
                end else begin
                    active_q <= 1'b0;
                end
            end
            if (cnv_done) begin
                fl_q <= 1'b0;
            end else if (!fl_q && (inj_pend || active_q)) begin
                fl_q    <= 1'b1;
                start_q <= 1'b1;
                if (inj_pend) begin
                    src_q     <= SRC_INJ;
                    fl_chan_q <= inj_chan;
                end else begin
                    src_q     <= SRC_STD;
                    fl_chan_q <= seq_chan_q;
                end
            end
        end
    end

    assign cnv_start = start_q;
    assign cnv_chan  = fl_chan_q;
    assign busy      = active_q;
    assign done_chan = fl_chan_q;

endmodule

// File: rtl/adc_seq_res.sv
module adc_seq_res
    import adc_seq_pkg::*;
#(
    parameter int CH_W   = 3,
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              std_done,
    input  logic              inj_done,
    input  logic [CH_W-1:0]   done_chan,
    input  logic [DATA_W-1:0] cnv_data,
    input  logic              inj_req,
    input  logic [CH_W-1:0]   inj_chan_in,
    input  logic              std_irq_clr,
    input  logic              inj_irq_clr,
    output logic [DATA_W-1:0] std_result,
    output logic [CH_W-1:0]   std_chan,
    output logic [DATA_W-1:0] inj_result,
    output logic              std_irq,
    output logic              inj_irq,
    output logic              inj_pend,
    output logic [CH_W-1:0]   inj_pend_chan
);

    logic [N_FLAGS-1:0] flag_set, flag_clr, flag_q;

    assign flag_set[FLAG_STD] = std_done;
    assign flag_set[FLAG_INJ] = inj_done;
    assign flag_clr[FLAG_STD] = std_irq_clr;
    assign flag_clr[FLAG_INJ] = inj_irq_clr;

    for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)              flag_q[i] <= 1'b0;
            else if (flag_set[i]) flag_q[i] <= 1'b1;
            else if (flag_clr[i]) flag_q[i] <= 1'b0;
        end
    end

    assign std_irq = flag_q[FLAG_STD];
    assign inj_irq = flag_q[FLAG_INJ];

    always_ff @(posedge clk) begin
        if (rst) begin
            std_result    <= '0;
            std_chan      <= '0;
            inj_result    <= '0;
            inj_pend      <= 1'b0;
            inj_pend_chan <= '0;
        end else begin
            if (std_done) begin
                std_result <= cnv_data;
                std_chan   <= done_chan;
            end
            if (inj_done) inj_result <= cnv_data;
            if (inj_req) begin
                inj_pend <= 1'b1;
                if (!inj_pend || inj_done) inj_pend_chan <= inj_chan_in;
            end else if (inj_done) begin
                inj_pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 10,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_mode,
    input  logic [CH_W-1:0]   cfg_chan,
    input  logic              cfg_start,
    input  logic              inj_req,
    input  logic [CH_W-1:0]   inj_chan,
    input  logic              std_irq_clr,
    input  logic              inj_irq_clr,
    output logic              cnv_start,
    output logic [CH_W-1:0]   cnv_chan,
    input  logic              cnv_done,
    input  logic [DATA_W-1:0] cnv_data,
    output logic              busy,
    output logic              inj_pending,
    output logic [DATA_W-1:0] std_result,
    output logic [CH_W-1:0]   std_result_chan,
    output logic [DATA_W-1:0] inj_result,
    output logic              std_irq,
    output logic              inj_irq
);

    scan_mode_e      sh_mode;
    logic [CH_W-1:0] sh_chan;
    logic            sh_start, sh_restart;
    logic            take, stop;
    logic            std_done, inj_done;
    logic [CH_W-1:0] done_chan;
    logic [CH_W-1:0] inj_pend_chan;

    adc_seq_cfg #(.CH_W(CH_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_wr),
        .wr_mode   (cfg_mode),
        .wr_chan   (cfg_chan),
        .wr_start  (cfg_start),
        .take_i    (take),
        .stop_i    (stop),
        .mode_o    (sh_mode),
        .chan_o    (sh_chan),
        .start_o   (sh_start),
        .restart_o (sh_restart)
    );

    adc_seq_core #(.CH_W(CH_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .sh_mode    (sh_mode),
        .sh_chan    (sh_chan),
        .sh_start   (sh_start),
        .sh_restart (sh_restart),
        .inj_pend   (inj_pending),
        .inj_chan   (inj_pend_chan),
        .cnv_done   (cnv_done),
        .cnv_start  (cnv_start),
        .cnv_chan   (cnv_chan),
        .busy       (busy),
        .std_done   (std_done),
        .inj_done   (inj_done),
        .done_chan  (done_chan),
        .take       (take),
        .stop       (stop)
    );

    adc_seq_res #(.CH_W(CH_W), .DATA_W(DATA_W)) u_res (
        .clk           (clk),
        .rst           (rst),
        .std_done      (std_done),
        .inj_done      (inj_done),
        .done_chan     (done_chan),
        .cnv_data      (cnv_data),
        .inj_req       (inj_req),
        .inj_chan_in   (inj_chan),
        .std_irq_clr   (std_irq_clr),
        .inj_irq_clr   (inj_irq_clr),
        .std_result    (std_result),
        .std_chan      (std_result_chan),
        .inj_result    (inj_result),
        .std_irq       (std_irq),
        .inj_irq       (inj_irq),
        .inj_pend      (inj_pending),
        .inj_pend_chan (inj_pend_chan)
    );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
    input logic clk,
    input logic rst,
    input logic cnv_start,
    input logic cnv_done,
    input logic busy,
    input logic inj_req,
    input logic inj_pending,
    input logic std_irq,
    input logic inj_irq,
    input logic std_irq_clr,
    input logic inj_irq_clr
);

    logic chk_fl;

    always_ff @(posedge clk) begin
        if (rst)            chk_fl <= 1'b0;
        else if (cnv_start) chk_fl <= 1'b1;
        else if (cnv_done)  chk_fl <= 1'b0;
    end

    assert_single_flight_R12: assert property (@(posedge clk) disable iff (rst)
        cnv_start |-> !chk_fl);

    assert_start_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        cnv_start |=> !cnv_start);

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !inj_pending) |=> !cnv_start);

    assert_inj_set_R10: assert property (@(posedge clk) disable iff (rst)
        inj_req |=> inj_pending);

    assert_inj_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (inj_pending && !cnv_done) |=> inj_pending);

    assert_inj_flag_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(inj_pending) |-> inj_irq);

    assert_busy_end_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> std_irq);

    assert_std_flag_hold_R13: assert property (@(posedge clk) disable iff (rst)
        (std_irq && !std_irq_clr) |=> std_irq);

    assert_inj_flag_hold_R13: assert property (@(posedge clk) disable iff (rst)
        (inj_irq && !inj_irq_clr) |=> inj_irq);

endmodule

bind adc_seq_ctrl adc_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cnv_start   (cnv_start),
    .cnv_done    (cnv_done),
    .busy        (busy),
    .inj_req     (inj_req),
    .inj_pending (inj_pending),
    .std_irq     (std_irq),
    .inj_irq     (inj_irq),
    .std_irq_clr (std_irq_clr),
    .inj_irq_clr (inj_irq_clr)
);

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;

    localparam int NCH  = 8;
    localparam int DW   = 10;
    localparam int CW   = 3;
    localparam int LAT  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_wr = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic [CW-1:0] cfg_chan = '0;
    logic cfg_start = 1'b0;
    logic inj_req = 1'b0;
    logic [CW-1:0] inj_chan = '0;
    logic std_irq_clr = 1'b0;
    logic inj_irq_clr = 1'b0;
    logic cnv_start;
    logic [CW-1:0] cnv_chan;
    logic cnv_done;
    logic [DW-1:0] cnv_data;
    logic busy, inj_pending, std_irq, inj_irq;
    logic [DW-1:0] std_result, inj_result;
    logic [CW-1:0] std_result_chan;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int log_ch [64];
    int log_n = 0;
    int overlap = 0;
    bit mon_fl = 1'b0;
    bit finished = 1'b0;
    int stub_cnt;
    logic [CW-1:0] stub_ch;

    always #2.5 clk = ~clk;

    adc_seq_ctrl #(.NUM_CH(NCH), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
        .cfg_chan(cfg_chan), .cfg_start(cfg_start), .inj_req(inj_req),
        .inj_chan(inj_chan), .std_irq_clr(std_irq_clr), .inj_irq_clr(inj_irq_clr),
        .cnv_start(cnv_start), .cnv_chan(cnv_chan), .cnv_done(cnv_done),
        .cnv_data(cnv_data), .busy(busy), .inj_pending(inj_pending),
        .std_result(std_result), .std_result_chan(std_result_chan),
        .inj_result(inj_result), .std_irq(std_irq), .inj_irq(inj_irq)
    );

    function automatic int conv_val(int ch);
        return ch * 17 + 3;
    endfunction

    // Converter model: fixed latency, value depends on channel
    always @(posedge clk) begin
        if (rst) begin
            stub_cnt <= 0;
            stub_ch  <= '0;
            cnv_done <= 1'b0;
            cnv_data <= '0;
        end else begin
            cnv_done <= 1'b0;
            if (stub_cnt != 0) begin
                stub_cnt <= stub_cnt - 1;
                if (stub_cnt == 1) begin
                    cnv_done <= 1'b1;
                    cnv_data <= DW'(conv_val(int'(stub_ch)));
                end
            end else if (cnv_start) begin
                stub_cnt <= LAT;
                stub_ch  <= cnv_chan;
            end
        end
    end

    // Monitor of issued conversions
    always @(negedge clk) begin
        if (!rst) begin
            if (cnv_start) begin
                if (log_n < 64) log_ch[log_n] = int'(cnv_chan);
                log_n = log_n + 1;
                if (mon_fl) overlap = overlap + 1;
                mon_fl = 1'b1;
            end
            if (cnv_done) mon_fl = 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !finished) begin
            finished = 1'b1;
            n_err = n_err + 1;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    task automatic chk_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_log(input string tag, input int n,
                           input int a0 = -1, input int a1 = -1, input int a2 = -1,
                           input int a3 = -1, input int a4 = -1);
        int e [5];
        e = '{a0, a1, a2, a3, a4};
        chk_eq({tag, " count"}, log_n, n);
        for (int i = 0; i < n && i < 5; i++)
            chk_eq($sformatf("%s entry%0d", tag, i), log_ch[i], e[i]);
    endtask

    task automatic cfg_write(input logic [1:0] m, input int ch, input logic st);
        cfg_mode  = m;
        cfg_chan  = CW'(ch);
        cfg_start = st;
        cfg_wr    = 1'b1;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic pulse_inj(input int ch);
        inj_chan = CW'(ch);
        inj_req  = 1'b1;
        @(negedge clk);
        inj_req  = 1'b0;
    endtask

    task automatic clear_flags();
        std_irq_clr = 1'b1;
        inj_irq_clr = 1'b1;
        @(negedge clk);
        std_irq_clr = 1'b0;
        inj_irq_clr = 1'b0;
    endtask

    task automatic wait_idle();
        int k = 0;
        repeat (3) @(negedge clk);
        while ((busy || inj_pending || stub_cnt != 0 || cnv_done) && k < 3000) begin
            @(negedge clk);
            k++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_log(input int n);
        int k = 0;
        while (log_n < n && k < 3000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic begin_test();
        wait_idle();
        clear_flags();
        log_n = 0;
    endtask

    task automatic t_reset();
        chk_eq("R11 busy after reset", int'(busy), 0);
        chk_eq("R10 pending after reset", int'(inj_pending), 0);
        chk_eq("R13 std flag after reset", int'(std_irq), 0);
        chk_eq("R13 inj flag after reset", int'(inj_irq), 0);
        chk_eq("R12 start after reset", int'(cnv_start), 0);
    endtask

    task automatic t_fixed_once();
        int k = 0;
        begin_test();
        cfg_write(2'b00, 4, 1'b1);
        chk_eq("R11 busy one clock after write", int'(busy), 0);
        @(negedge clk);
        chk_eq("R11 busy two clocks after write", int'(busy), 1);
        while (!std_irq && k < 100) begin @(negedge clk); k++; end
        chk_eq("R11 busy low when result lands", int'(busy), 0);
        wait_idle();
        chk_log("R1 fixed once", 1, 4);
        chk_eq("R1 result", int'(std_result), conv_val(4));
        chk_eq("R1 result chan", int'(std_result_chan), 4);
        chk_eq("R1 std flag", int'(std_irq), 1);
    endtask

    task automatic t_idle_no_start();
        begin_test();
        cfg_write(2'b10, 5, 1'b0);
        repeat (30) @(negedge clk);
        cfg_write(2'b11, 6, 1'b0);
        repeat (30) @(negedge clk);
        chk_eq("R7 no conversion", log_n, 0);
        chk_eq("R7 busy stays low", int'(busy), 0);
        chk_eq("R7 no flag", int'(std_irq), 0);
    endtask

    task automatic t_scan_once();
        begin_test();
        cfg_write(2'b10, 3, 1'b1);
        wait_idle();
        chk_log("R3 scan once", 4, 3, 2, 1, 0);
        chk_eq("R3 last chan", int'(std_result_chan), 0);
        chk_eq("R3 last value", int'(std_result), conv_val(0));
        chk_eq("R3 idle", int'(busy), 0);
    endtask

    task automatic t_scan_loop();
        begin_test();
        cfg_write(2'b11, 2, 1'b1);
        wait_log(5);
        cfg_write(2'b11, 2, 1'b0);
        wait_idle();
        chk_eq("R4 count", log_n, 6);
        for (int i = 0; i < 6; i++)
            chk_eq($sformatf("R4 entry%0d", i), log_ch[i], 2 - (i % 3));
    endtask

    task automatic t_fixed_loop();
        begin_test();
        cfg_write(2'b01, 6, 1'b1);
        wait_log(2);
        cfg_write(2'b01, 1, 1'b1);
        wait_log(4);
        cfg_write(2'b01, 1, 1'b0);
        wait_idle();
        chk_log("R2 fixed repeat", 4, 6, 6, 1, 1);
        chk_eq("R2 stopped", int'(busy), 0);
    endtask

    task automatic t_morph();
        begin_test();
        cfg_write(2'b00, 4, 1'b1);
        wait_log(1);
        cfg_write(2'b10, 7, 1'b0);
        wait_idle();
        chk_log("R5 fixed to scan", 5, 4, 3, 2, 1, 0);
    endtask

    task automatic t_scan_hold();
        begin_test();
        cfg_write(2'b10, 3, 1'b1);
        wait_log(1);
        cfg_write(2'b00, 6, 1'b1);
        wait_idle();
        chk_log("R6 scan holds writes", 5, 3, 2, 1, 0, 6);
        chk_eq("R6 final chan", int'(std_result_chan), 6);
    endtask

    task automatic t_inj_idle();
        begin_test();
        pulse_inj(5);
        chk_eq("R10 pending set", int'(inj_pending), 1);
        wait_idle();
        chk_log("R8 injection alone", 1, 5);
        chk_eq("R8 inj result", int'(inj_result), conv_val(5));
        chk_eq("R8 inj flag", int'(inj_irq), 1);
        chk_eq("R8 std flag untouched", int'(std_irq), 0);
        chk_eq("R10 pending cleared", int'(inj_pending), 0);
    endtask

    task automatic t_inj_vs_start();
        for (int d = 0; d <= 10; d++) begin
            begin_test();
            pulse_inj(2);
            repeat (d) @(negedge clk);
            cfg_write(2'b00, 6, 1'b1);
            wait_idle();
            chk_log($sformatf("R9 offset %0d", d), 2, 2, 6);
            chk_eq($sformatf("R9 inj value offset %0d", d), int'(inj_result), conv_val(2));
            chk_eq($sformatf("R9 inj flag offset %0d", d), int'(inj_irq), 1);
            chk_eq($sformatf("R9 std chan offset %0d", d), int'(std_result_chan), 6);
        end
    endtask

    task automatic t_inj_waits();
        begin_test();
        cfg_write(2'b00, 3, 1'b1);
        wait_log(1);
        pulse_inj(5);
        chk_eq("R10 pending while std runs", int'(inj_pending), 1);
        cfg_write(2'b00, 3, 1'b0);
        chk_eq("R10 pending survives stop write", int'(inj_pending), 1);
        wait_idle();
        chk_log("R8 no preemption", 2, 3, 5);
        chk_eq("R8 inj value", int'(inj_result), conv_val(5));
    endtask

    task automatic t_inj_priority();
        begin_test();
        cfg_write(2'b01, 1, 1'b1);
        wait_log(1);
        pulse_inj(7);
        wait_log(3);
        cfg_write(2'b01, 1, 1'b0);
        wait_idle();
        chk_log("R8 injection first at free slot", 3, 1, 7, 1);
    endtask

    task automatic t_flags();
        begin_test();
        pulse_inj(4);
        wait_idle();
        cfg_write(2'b00, 2, 1'b1);
        wait_idle();
        repeat (5) @(negedge clk);
        chk_eq("R13 std flag held", int'(std_irq), 1);
        chk_eq("R13 inj flag held", int'(inj_irq), 1);
        std_irq_clr = 1'b1;
        @(negedge clk);
        std_irq_clr = 1'b0;
        chk_eq("R13 std flag cleared", int'(std_irq), 0);
        chk_eq("R13 inj flag kept", int'(inj_irq), 1);
        inj_irq_clr = 1'b1;
        @(negedge clk);
        inj_irq_clr = 1'b0;
        chk_eq("R13 inj flag cleared", int'(inj_irq), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fixed_once();
        t_idle_no_start();
        t_scan_once();
        t_scan_loop();
        t_fixed_loop();
        t_morph();
        t_scan_hold();
        t_inj_idle();
        t_inj_vs_start();
        t_inj_waits();
        t_inj_priority();
        t_flags();
        chk_eq("R12 overlapping starts", overlap, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule